// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a small processor built around one 16-bit accumulator. It fetches 8-bit instructions from an internal instruction store and runs them against a 32-word data RAM. Each instruction finishes in one clock. An instruction carries a 3-bit operation code in its upper bits and a 5-bit immediate in its lower bits. Depending on the operation, the immediate is a signed constant, a signed branch offset or an unsigned RAM address.

A program goes in through a write port on the instruction store. The port can be used at any time, and it is normally used while reset is held. When reset is released, execution starts at address 0. The core exposes the program counter and the accumulator for observation. It raises a sticky halt flag when it meets one of the three unused operation codes.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC, the accumulator and `halted` are all cleared to zero.
- R2: Code 000 (bits [7:5]) clears the accumulator whatever bits [4:0] hold, and the PC advances by 1.
- R3: Code 001 adds bits [4:0], sign-extended from bit 4, to the accumulator modulo 2^16, and the PC advances by 1.
- R4: Code 010 writes the accumulator into RAM word bits [4:0], read as unsigned. The accumulator is unchanged and the PC advances by 1.
- R5: Code 011 adds RAM word bits [4:0] to the accumulator modulo 2^16, and the PC advances by 1.
- R6: Code 100 with a zero accumulator sets the PC to its own address + 1 + the sign-extended bits [4:0].
- R7: Code 100 with a nonzero accumulator advances the PC by 1 and leaves the accumulator unchanged.
- R8: Codes 101, 110 and 111 set `halted`. From then on the PC and the accumulator stay frozen until reset.
- R9: The 8-bit PC wraps modulo 256, both on a sequential step and on a branch.
- R10: Reset leaves the data RAM contents unchanged.
- R11: Exactly one instruction retires per clock while the core runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Write strobe for the instruction store |
| load_addr | input | 8 | Instruction store write address |
| load_data | input | 8 | Instruction byte to write |
| halted | output | 1 | Sticky halt flag |
| pc_out | output | 8 | Current program counter |
| acc_out | output | 16 | Current accumulator value |

## Verification
The bench runs branches in both directions. One jumps forward 8 from address 7 and one jumps back 11 from address 15, so a core that adds the offset to the unincremented PC lands one slot short. A core that ignores the accumulator test falls through the wrong way at the untaken branch. Another program moves the PC through 255 to 0 and branches backward from address 0 to 254. A PC wider than 8 bits, or an offset that is not sign-extended, would never return to the program.

Accumulator wrap-around is driven by an immediate of -1 and by loading 0xFFFF from RAM, where a replace-instead-of-add load gives 0xFFFF rather than 0xFFFE. A clear with nonzero immediate bits catches a clear that uses the immediate. All three halt codes are checked to freeze the PC and the accumulator. A value stored before a second reset must still be read afterwards, which exposes any RAM clearing.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 3;

  localparam logic [OPC_W-1:0] OPC_CLR   = 3'b000;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 3'b001;
  localparam logic [OPC_W-1:0] OPC_STORE = 3'b010;
  localparam logic [OPC_W-1:0] OPC_ACCUM = 3'b011;
  localparam logic [OPC_W-1:0] OPC_BRZ   = 3'b100;
endpackage

// File: rtl/acc_ram.sv
module acc_ram #(
  parameter int AW = 5,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int WORDS = 1 << AW;

  logic [W-1:0] mem [WORDS];

  // contents are never reset
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/acc_decode.sv
module acc_decode #(
  parameter int IMMW = 5,
  localparam int IW  = acc_pkg::OPC_W + IMMW
) (
  input  logic [IW-1:0]   instr,
  input  logic            stopped,
  output logic [IMMW-1:0] imm,
  output logic            do_clr,
  output logic            do_addi,
  output logic            do_store,
  output logic            do_accum,
  output logic            do_brz,
  output logic            do_halt
);
  import acc_pkg::*;

  logic [OPC_W-1:0] opc;
  logic             live;

  assign opc  = instr[IW-1 -: OPC_W];
  assign imm  = instr[IMMW-1:0];
  assign live = !stopped;

  always_comb begin
    do_clr   = 1'b0;
    do_addi  = 1'b0;
    do_store = 1'b0;
    do_accum = 1'b0;
    do_brz   = 1'b0;
    do_halt  = 1'b0;
    if (live) begin
      unique case (opc)
        OPC_CLR:   do_clr   = 1'b1;
        OPC_ADDI:  do_addi  = 1'b1;
        OPC_STORE: do_store = 1'b1;
        OPC_ACCUM: do_accum = 1'b1;
        OPC_BRZ:   do_brz   = 1'b1;
        default:   do_halt  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int DW   = 16,
  parameter int PCW  = 8,
  parameter int IMMW = 5,
  localparam int IW  = acc_pkg::OPC_W + IMMW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_en,
  input  logic [PCW-1:0] load_addr,
  input  logic [IW-1:0]  load_data,
  output logic           halted,
  output logic [PCW-1:0] pc_out,
  output logic [DW-1:0]  acc_out
);
  function automatic logic [DW-1:0] f_sext_data(input logic [IMMW-1:0] v);
    return {{(DW-IMMW){v[IMMW-1]}}, v};
  endfunction

  function automatic logic [PCW-1:0] f_brz_target(input logic [PCW-1:0] pc,
                                                  input logic [IMMW-1:0] v);
    logic [PCW-1:0] off;
    off = {{(PCW-IMMW){v[IMMW-1]}}, v};
    return pc + PCW'(1) + off;
  endfunction

  function automatic logic [DW-1:0] f_wrap_add(input logic [DW-1:0] a,
                                               input logic [DW-1:0] b);
    return a + b;
  endfunction

  logic [PCW-1:0]  pc_q;
  logic [DW-1:0]   acc_q;
  logic            halt_q;
  logic [IW-1:0]   instr;
  logic [IMMW-1:0] imm;
  logic [DW-1:0]   imm_sx;
  logic [DW-1:0]   ram_word;
  logic            do_clr, do_addi, do_store, do_accum, do_brz, do_halt;
  logic            acc_is_zero;
  logic            take_brz;
  logic            ram_we;
  logic [PCW-1:0]  pc_seq;
  logic [PCW-1:0]  pc_jump;

  acc_ram #(.AW(PCW), .W(IW)) u_istore (
    .clk   (clk),
    .we    (load_en),
    .waddr (load_addr),
    .wdata (load_data),
    .raddr (pc_q),
    .rdata (instr)
  );

  acc_decode #(.IMMW(IMMW)) u_dec (
    .instr    (instr),
    .stopped  (halt_q),
    .imm      (imm),
    .do_clr   (do_clr),
    .do_addi  (do_addi),
    .do_store (do_store),
    .do_accum (do_accum),
    .do_brz   (do_brz),
    .do_halt  (do_halt)
  );

  assign ram_we = do_store && !rst;

  acc_ram #(.AW(IMMW), .W(DW)) u_dram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (imm),
    .wdata (acc_q),
    .raddr (imm),
    .rdata (ram_word)
  );

  assign imm_sx      = f_sext_data(imm);
  assign acc_is_zero = (acc_q == '0);
  assign take_brz    = do_brz && acc_is_zero;
  assign pc_seq      = pc_q + PCW'(1);
  assign pc_jump     = f_brz_target(pc_q, imm);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      acc_q  <= '0;
      halt_q <= 1'b0;
    end else if (do_halt) begin
      halt_q <= 1'b1;
    end else if (!halt_q) begin
      pc_q <= take_brz ? pc_jump : pc_seq;
      if (do_clr)        acc_q <= '0;
      else if (do_addi)  acc_q <= f_wrap_add(acc_q, imm_sx);
      else if (do_accum) acc_q <= f_wrap_add(acc_q, ram_word);
    end
  end

  assign halted  = halt_q;
  assign pc_out  = pc_q;
  assign acc_out = acc_q;

  // R2: clear zeroes the accumulator
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    do_clr |=> (acc_q == '0));

  // R3: immediate add wraps modulo 2^DW
  p_addi_r3: assert property (@(posedge clk) disable iff (rst)
    do_addi |=> (acc_q == $past(acc_q) + $past(imm_sx)));

  // R4: store keeps the accumulator
  p_store_keep_r4: assert property (@(posedge clk) disable iff (rst)
    do_store |=> $stable(acc_q));

  // R6: taken branch lands on the computed target
  p_brz_taken_r6: assert property (@(posedge clk) disable iff (rst)
    take_brz |=> (pc_q == $past(pc_jump)));

  // R7: untaken branch falls through
  p_brz_fall_r7: assert property (@(posedge clk) disable iff (rst)
    (do_brz && !acc_is_zero) |=> ((pc_q == $past(pc_q) + PCW'(1)) && $stable(acc_q)));

  // R8: halt is sticky and freezes state
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> (halt_q && $stable(pc_q) && $stable(acc_q)));

  // R8: halt op keeps pc
  p_halt_entry_r8: assert property (@(posedge clk) disable iff (rst)
    do_halt |=> (halt_q && $stable(pc_q)));

  // R11: every non-branch instruction retires in one clock
  p_one_step_r11: assert property (@(posedge clk) disable iff (rst)
    (!halt_q && !do_brz && !do_halt) |=> (pc_q == $past(pc_q) + PCW'(1)));

  // R4: the RAM is written only by a store
  p_ram_we_r4: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (!halt_q && !do_halt));
endmodule

// File: tb/acc_core_test.sv
module acc_core_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        load_en;
  logic [7:0]  load_addr;
  logic [7:0]  load_data;
  logic        halted;
  logic [7:0]  pc_out;
  logic [15:0] acc_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  acc_core uut (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_addr (load_addr),
    .load_data (load_data),
    .halted    (halted),
    .pc_out    (pc_out),
    .acc_out   (acc_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [7:0] pc,
                           input logic [15:0] acc, input logic h);
    chk({req, " pc"}, 32'(pc_out), 32'(pc));
    chk({req, " acc"}, 32'(acc_out), 32'(acc));
    chk({req, " halt"}, 32'(halted), 32'(h));
  endtask

  task automatic put(input logic [7:0] a, input logic [7:0] d);
    load_en   = 1'b1;
    load_addr = a;
    load_data = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic begin_prog(input logic [7:0] fillv);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) put(8'(i), fillv);
  endtask

  task automatic go();
    rst = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    begin_prog(8'hE0);
    chk_state("R1 initial", 8'd0, 16'd0, 1'b0);
    put(8'd0, 8'h25);
    go();
    step(3);
    chk_state("R8 pre-reset", 8'd1, 16'd5, 1'b1);
    rst = 1'b1;
    step(1);
    chk_state("R1 after run", 8'd0, 16'd0, 1'b0);
  endtask

  task automatic t_clear_add();
    begin_prog(8'hE0);
    put(8'd0, 8'h25);
    put(8'd1, 8'h3F);
    put(8'd2, 8'h16);
    put(8'd3, 8'h30);
    put(8'd4, 8'h2F);
    put(8'd5, 8'h21);
    go();
    step(1); chk_state("R3 add +5",  8'd1, 16'd5,    1'b0);
    step(1); chk_state("R3 add -1",  8'd2, 16'd4,    1'b0);
    step(1); chk_state("R2 clear with imm", 8'd3, 16'd0, 1'b0);
    step(1); chk_state("R3 add -16", 8'd4, 16'hFFF0, 1'b0);
    step(1); chk_state("R11 add +15", 8'd5, 16'hFFFF, 1'b0);
    step(1); chk_state("R3 wrap to zero", 8'd6, 16'h0000, 1'b0);
    step(1); chk_state("R8 halt", 8'd6, 16'h0000, 1'b1);
  endtask

  task automatic t_mem();
    begin_prog(8'hE0);
    put(8'd0,  8'h27);
    put(8'd1,  8'h5F);
    put(8'd2,  8'h40);
    put(8'd3,  8'h00);
    put(8'd4,  8'h7F);
    put(8'd5,  8'h60);
    put(8'd6,  8'h32);
    put(8'd7,  8'h3F);
    put(8'd8,  8'h43);
    put(8'd9,  8'h63);
    go();
    step(2); chk_state("R4 store 31", 8'd2, 16'd7, 1'b0);
    step(2); chk_state("R2 clear", 8'd4, 16'd0, 1'b0);
    step(1); chk_state("R5 load 31", 8'd5, 16'd7, 1'b0);
    step(1); chk_state("R5 load 0", 8'd6, 16'd14, 1'b0);
    step(1); chk_state("R3 add -14", 8'd7, 16'd0, 1'b0);
    step(3); chk_state("R5 load wraps", 8'd10, 16'hFFFE, 1'b0);
    step(1); chk_state("R8 halt after mem", 8'd10, 16'hFFFE, 1'b1);
  endtask

  task automatic t_branch();
    begin_prog(8'hE0);
    put(8'd0,  8'h00);
    put(8'd1,  8'h85);
    put(8'd7,  8'h88);
    put(8'd16, 8'h21);
    put(8'd17, 8'h83);
    put(8'd18, 8'h00);
    put(8'd19, 8'h9B);
    put(8'd15, 8'h95);
    put(8'd5,  8'hA0);
    go();
    step(2); chk_state("R6 fwd +5 from 1", 8'd7, 16'd0, 1'b0);
    step(1); chk_state("R6 fwd +8 from 7", 8'd16, 16'd0, 1'b0);
    step(1); chk_state("R3 add before test", 8'd17, 16'd1, 1'b0);
    step(1); chk_state("R7 untaken", 8'd18, 16'd1, 1'b0);
    step(2); chk_state("R6 back -5 from 19", 8'd15, 16'd0, 1'b0);
    step(1); chk_state("R6 back -11 from 15", 8'd5, 16'd0, 1'b0);
    step(1); chk_state("R8 halt at 5", 8'd5, 16'd0, 1'b1);
    step(4); chk_state("R8 stays frozen", 8'd5, 16'd0, 1'b1);
  endtask

  task automatic t_halt_codes();
    for (int c = 5; c < 8; c++) begin
      begin_prog(8'h00);
      put(8'd0, 8'h23);
      put(8'd1, {3'(c), 5'h1F});
      put(8'd2, 8'h21);
      go();
      step(2); chk_state($sformatf("R8 code %0d", c), 8'd1, 16'd3, 1'b1);
      step(3); chk_state($sformatf("R8 code %0d held", c), 8'd1, 16'd3, 1'b1);
    end
  endtask

  task automatic t_wrap();
    begin_prog(8'hE0);
    put(8'd0,   8'h9D);
    put(8'd254, 8'h21);
    put(8'd255, 8'h21);
    go();
    step(1); chk_state("R9 branch wraps back", 8'd254, 16'd0, 1'b0);
    step(1); chk_state("R11 step to 255", 8'd255, 16'd1, 1'b0);
    step(1); chk_state("R9 pc wraps to 0", 8'd0, 16'd2, 1'b0);
    step(1); chk_state("R7 untaken at 0", 8'd1, 16'd2, 1'b0);
    step(1); chk_state("R8 halt at 1", 8'd1, 16'd2, 1'b1);
  endtask

  task automatic t_ram_persist();
    begin_prog(8'hE0);
    put(8'd0, 8'h29);
    put(8'd1, 8'h4C);
    go();
    step(3);
    chk_state("R4 stored 9", 8'd2, 16'd9, 1'b1);
    begin_prog(8'hE0);
    put(8'd0, 8'h6C);
    go();
    step(1); chk_state("R10 ram kept over reset", 8'd1, 16'd9, 1'b0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst       = 1'b1;
    load_en   = 1'b0;
    load_addr = '0;
    load_data = '0;
    @(negedge clk);
    t_reset();
    t_clear_add();
    t_mem();
    t_branch();
    t_halt_codes();
    t_wrap();
    t_ram_persist();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule